// File: doc/BRIEF.md
# Flash Program/Erase Sequencer with Completion Polling

This block carries out an internally timed word program or a region erase on a 32K x 16 non-volatile array. It takes an already decoded command, drives a synchronous array port (address, write data, write strobe, and read data that returns one cycle after the address), and stays busy until the operation's cycle budget has run out. A program reads the old word and writes back the old word ANDed with the new data, so bits can only go from 1 to 0. An erase walks its address range one word per cycle, writing all-ones, and then waits out a fixed settle time.

The host finds out that an operation has finished by reading. While the sequencer is busy, every read returns a status word instead of array data. Bit 7 of that word is the inverse of the value the operation is trying to leave in bit 7. Bit 6 changes value on every read. Once the operation ends, reads return true array contents again and the next command is accepted. A boot-lock input protects the low region of the array from programs and from the chip-wide erase.

Top module: `flash_op_sequencer`

## Requirements
- R1: While reset is held and directly after it is released, `busy`, `rd_valid` and `arr_we` are 0.
- R2: When `rd_en` is sampled high at a clock edge while `busy` is low, `rd_valid` is 1 after the next edge and `rd_data` carries the array word at `rd_addr`.
- R3: A program command (`cmd_op` = 2'b01) leaves the addressed word equal to the old word ANDed with `cmd_data`. `busy` rises at the accepting edge and stays high for exactly PROG_CYCLES cycles.
- R4: A read sampled while `busy` is high returns a status word with every bit 0 except bits 7 and 6. Bit 7 is the inverse of `cmd_data[7]` for a program and 0 for an erase.
- R5: Bit 6 of the status word is 0 on the first busy read of an operation and changes value on each later busy read of that operation.
- R6: A main erase (`cmd_op` = 2'b11) sets every word from 2^BOOT_W up to the top address to all-ones, leaves the words below 2^BOOT_W unchanged, and keeps `busy` high for (2^ADDR_W - 2^BOOT_W) + ERASE_CYCLES cycles.
- R7: A chip erase (`cmd_op` = 2'b10) accepted with `boot_lock` low sets every word to all-ones and keeps `busy` high for 2^ADDR_W + ERASE_CYCLES cycles.
- R8: A chip erase accepted with `boot_lock` high acts exactly like a main erase, in both contents and busy length.
- R9: A program accepted with `boot_lock` high to an address below 2^BOOT_W does not change the array but still keeps `busy` high for PROG_CYCLES cycles. Programs above that region still take effect.
- R10: `cmd_valid` is ignored while `busy` is high, and also when `cmd_op` = 2'b00.
- R11: The first read sampled after `busy` falls returns the true word the operation left behind, and a command in that state is accepted.
- R12: `arr_we` is only ever high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 2 | 01 program, 10 chip erase, 11 main erase, 00 none |
| cmd_addr | input | ADDR_W | Word address for a program |
| cmd_data | input | DATA_W | Data for a program |
| boot_lock | input | 1 | Protects the low 2^BOOT_W words; sampled at command acceptance |
| rd_en | input | 1 | Host read request |
| rd_addr | input | ADDR_W | Host read address |
| rd_valid | output | 1 | Read result valid, one cycle after the request |
| rd_data | output | DATA_W | Array word when idle, status word when busy |
| busy | output | 1 | Operation in progress |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | DATA_W | Array write data |
| arr_we | output | 1 | Array write strobe |
| arr_rdata | input | DATA_W | Array read data, valid one cycle after the address |

## Verification
A read result is due one edge after the request, so the scoreboard pushes the expected word when it drives `rd_en` and pops it at the next falling edge where `rd_valid` is high. Busy length is measured by counting the falling edges at which `busy` is seen high after the accepting edge. That count must equal PROG_CYCLES for a program and the sweep length plus ERASE_CYCLES for an erase. Status reads are driven only at falling edges where `busy` is observed high, so the edge that samples them falls inside the operation. The first array read is driven at the falling edge where `busy` is first seen low.

// File: rtl/fseq_pkg.sv
`timescale 1ns/1ps
package fseq_pkg;
    // Command codes on cmd_op
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PROG = 2'b01,
        OP_CHIP = 2'b10,
        OP_MAIN = 2'b11
    } op_e;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_STORE = 3'd2,
        ST_SWEEP = 3'd3,
        ST_HOLD  = 3'd4
    } st_e;
endpackage

// File: rtl/fseq_hold_timer.sv
`timescale 1ns/1ps
module fseq_hold_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = cnt_q + ONE_C;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == limit);
endmodule

// File: rtl/fseq_poll_status.sv
`timescale 1ns/1ps
module fseq_poll_status #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              flag_in,
    input  logic              status_rd,
    output logic [DATA_W-1:0] status_word
);
    typedef struct packed {
        logic flag;
        logic tog;
    } stat_t;

    stat_t d, q;

    always_comb begin
        d = q;
        if (start) begin
            d.flag = flag_in;
            d.tog  = 1'b0;
        end else if (status_rd) begin
            d.tog = ~q.tog;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        status_word    = '0;
        status_word[7] = q.flag;
        status_word[6] = q.tog;
    end
endmodule

// File: rtl/flash_op_sequencer.sv
`timescale 1ns/1ps
module flash_op_sequencer
    import fseq_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int DATA_W       = 16,
    parameter int BOOT_W       = 13,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              boot_lock,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              arr_we,
    input  logic [DATA_W-1:0] arr_rdata
);
    localparam int LIM_MAX = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(LIM_MAX + 1);
    localparam logic [ADDR_W-1:0] BOOT_BASE = ADDR_W'(1) << BOOT_W;
    localparam logic [ADDR_W-1:0] ONE_A     = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  PROG_LIM  = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0]  ERASE_LIM = CNT_W'(ERASE_CYCLES - 1);

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              lock;
        logic [ADDR_W-1:0] sweep;
        logic              rd_valid;
        logic              rd_arr;
        logic [DATA_W-1:0] rd_word;
    } regs_t;

    regs_t d, q;

    logic              tmr_clear, tmr_run, tmr_expired;
    logic [CNT_W-1:0]  tmr_limit;
    logic              stat_start, stat_flag, stat_rd;
    logic [DATA_W-1:0] stat_word;
    logic              accept;
    logic              target_locked;

    // Signals exposed to the bound checker
    logic lock_q;
    logic op_is_prog;
    logic rd_from_arr;

    fseq_hold_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .run     (tmr_run),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    fseq_poll_status #(.DATA_W(DATA_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (stat_start),
        .flag_in     (stat_flag),
        .status_rd   (stat_rd),
        .status_word (stat_word)
    );

    always_comb begin
        d          = q;
        arr_addr   = rd_addr;
        arr_wdata  = '1;
        arr_we     = 1'b0;
        tmr_clear  = 1'b0;
        tmr_run    = 1'b0;
        stat_start = 1'b0;
        stat_flag  = 1'b0;
        stat_rd    = 1'b0;
        tmr_limit  = (q.op == OP_PROG) ? PROG_LIM : ERASE_LIM;

        accept        = (q.st == ST_IDLE) && cmd_valid && (op_e'(cmd_op) != OP_NONE);
        target_locked = q.lock && (q.addr < BOOT_BASE);

        // Host read path: array when idle, status word when busy
        d.rd_valid = rd_en;
        d.rd_arr   = (q.st == ST_IDLE);
        if (rd_en && (q.st != ST_IDLE)) begin
            stat_rd   = 1'b1;
            d.rd_word = stat_word;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.op       = op_e'(cmd_op);
                    d.addr     = cmd_addr;
                    d.data     = cmd_data;
                    d.lock     = boot_lock;
                    tmr_clear  = 1'b1;
                    stat_start = 1'b1;
                    if (op_e'(cmd_op) == OP_PROG) begin
                        stat_flag = ~cmd_data[7];
                        d.st      = ST_FETCH;
                    end else begin
                        stat_flag = 1'b0;
                        d.st      = ST_SWEEP;
                        if ((op_e'(cmd_op) == OP_CHIP) && !boot_lock) begin
                            d.sweep = '0;
                        end else begin
                            d.sweep = BOOT_BASE;
                        end
                    end
                end
            end
            ST_FETCH: begin
                arr_addr = q.addr;
                tmr_run  = 1'b1;
                d.st     = ST_STORE;
            end
            ST_STORE: begin
                arr_addr  = q.addr;
                arr_wdata = arr_rdata & q.data;
                arr_we    = !target_locked;
                tmr_run   = 1'b1;
                d.st      = ST_HOLD;
            end
            ST_SWEEP: begin
                arr_addr  = q.sweep;
                arr_wdata = '1;
                arr_we    = 1'b1;
                tmr_clear = 1'b1;
                if (q.sweep == '1) begin
                    d.st = ST_HOLD;
                end else begin
                    d.sweep = q.sweep + ONE_A;
                end
            end
            ST_HOLD: begin
                tmr_run = 1'b1;
                if (tmr_expired) begin
                    d.st = ST_IDLE;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, op: OP_NONE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.st != ST_IDLE);
    assign rd_valid    = q.rd_valid;
    assign rd_data     = q.rd_arr ? arr_rdata : q.rd_word;
    assign lock_q      = q.lock;
    assign op_is_prog  = (q.op == OP_PROG);
    assign rd_from_arr = q.rd_arr;
endmodule

// File: rtl/fseq_sva.sv
`timescale 1ns/1ps
module fseq_sva #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 16,
    parameter int BOOT_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              busy,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [DATA_W-1:0] arr_wdata,
    input logic              arr_we,
    input logic [DATA_W-1:0] arr_rdata,
    input logic              lock_q,
    input logic              op_is_prog,
    input logic              rd_from_arr
);
    localparam logic [ADDR_W-1:0] BOOT_BASE = ADDR_W'(1) << BOOT_W;
    localparam logic [DATA_W-1:0] POLL_MASK = DATA_W'(8'hC0);

    a_r12_we_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    a_r9_boot_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && lock_q) |-> (arr_addr >= BOOT_BASE));

    a_r3_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && op_is_prog) |-> ((arr_wdata & ~arr_rdata) == '0));

    a_r6_erase_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && !op_is_prog) |-> (arr_wdata == '1));

    a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r10_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && (cmd_op != 2'b00)) |=> busy);

    a_r10_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_valid && (cmd_op != 2'b00))) |=> !busy);

    a_r4_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_from_arr) |-> ((rd_data & ~POLL_MASK) == '0));
endmodule

bind flash_op_sequencer fseq_sva #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BOOT_W (BOOT_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .busy        (busy),
    .arr_addr    (arr_addr),
    .arr_wdata   (arr_wdata),
    .arr_we      (arr_we),
    .arr_rdata   (arr_rdata),
    .lock_q      (lock_q),
    .op_is_prog  (op_is_prog),
    .rd_from_arr (rd_from_arr)
);

// File: tb/flash_op_sequencer_tb.sv
`timescale 1ns/1ps
module flash_op_sequencer_tb;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 16;
    localparam int BOOT_W = 13;
    localparam int PROG_CYCLES  = 8;
    localparam int ERASE_CYCLES = 16;
    localparam int BOOT_SIZE = 1 << BOOT_W;
    localparam int FULL_SIZE = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'b00;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic              boot_lock = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_valid, busy, arr_we;
    logic [DATA_W-1:0] rd_data, arr_wdata;
    logic [DATA_W-1:0] arr_rdata = '1;
    logic [ADDR_W-1:0] arr_addr;

    always #2 clk = ~clk;

    flash_op_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_W(BOOT_W),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .boot_lock(boot_lock),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_we(arr_we),
        .arr_rdata(arr_rdata)
    );

    // Synchronous array model, sparse, blank words read as all-ones
    logic [DATA_W-1:0] mem [int];
    always @(posedge clk) begin
        arr_rdata <= mem.exists(int'(arr_addr)) ? mem[int'(arr_addr)] : '1;
        if (arr_we) mem[int'(arr_addr)] = arr_wdata;
    end

    // Expected contents, maintained from the requirements
    logic [DATA_W-1:0] ref_mem [int];
    function automatic logic [DATA_W-1:0] ref_get(int a);
        return ref_mem.exists(a) ? ref_mem[a] : '1;
    endfunction
    function automatic void ref_blank(int lo, int hi);
        for (int a = lo; a <= hi; a++) if (ref_mem.exists(a)) ref_mem.delete(a);
    endfunction

    int total = 0;
    int bad = 0;
    logic [DATA_W-1:0] exp_q [$];
    string             tag_q [$];

    function automatic void chk(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    // Monitor: pops one expected word per valid read result
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected rd_valid", 1, 0);
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // Driver: one idle read, expectation from the reference contents
    task automatic do_read(int a, string tag);
        rd_en   = 1'b1;
        rd_addr = ADDR_W'(a);
        exp_q.push_back(ref_get(a));
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Driver: issue a command, poll with status reads, measure busy length
    task automatic run_op(logic [1:0] op, int a, logic [DATA_W-1:0] dat,
                          int exp_len, int n_stat, bit inject, string tag);
        int cnt = 0;
        int left = n_stat;
        logic tog = 1'b0;
        logic flag = (op == 2'b01) ? ~dat[7] : 1'b0;
        logic [DATA_W-1:0] sw;
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = ADDR_W'(a); cmd_data = dat;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) begin
            cnt++;
            if (inject && cnt == 1) begin
                cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 15'h3001; cmd_data = '0;
            end else begin
                cmd_valid = 1'b0;
            end
            if (left > 0) begin
                rd_en = 1'b1; rd_addr = ADDR_W'(a);
                sw = '0; sw[7] = flag; sw[6] = tog;
                exp_q.push_back(sw);
                tag_q.push_back("R4/R5 status word");
                tog = ~tog;
                left--;
            end else begin
                rd_en = 1'b0;
            end
            @(negedge clk);
        end
        rd_en = 1'b0; cmd_valid = 1'b0;
        chk(tag, cnt, exp_len);
        if (op == 2'b01) begin
            if (!(boot_lock && a < BOOT_SIZE)) ref_mem[a] = ref_get(a) & dat;
        end else if (op == 2'b10 && !boot_lock) begin
            ref_blank(0, FULL_SIZE - 1);
        end else begin
            ref_blank(BOOT_SIZE, FULL_SIZE - 1);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 arr_we in reset", arr_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 rd_valid after reset", rd_valid, 0);
        chk("R1 arr_we after reset", arr_we, 0);

        do_read(16'h0123, "R2 blank read");

        // R3 program, with status polling (R4, R5) and read-back (R11)
        run_op(2'b01, 16'h2345, 16'hA5C3, PROG_CYCLES, 3, 0, "R3 program busy length");
        do_read(16'h2345, "R11 first read after program");
        run_op(2'b01, 16'h2345, 16'h0F0F, PROG_CYCLES, 2, 0, "R3 second program busy length");
        do_read(16'h2345, "R3 AND of old and new");

        // R10 command during busy ignored
        run_op(2'b01, 16'h3000, 16'h1234, PROG_CYCLES, 0, 1, "R10 busy length with injected cmd");
        do_read(16'h3001, "R10 injected program had no effect");
        do_read(16'h3000, "R11 programmed word");

        // R10 null op ignored
        cmd_valid = 1'b1; cmd_op = 2'b00;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R10 null op stays idle", busy, 0);
        @(negedge clk);
        chk("R10 null op stays idle later", busy, 0);

        // R9 lock against boot programs
        run_op(2'b01, 16'h0100, 16'h1357, PROG_CYCLES, 0, 0, "R3 boot program unlocked");
        run_op(2'b01, 16'h1FFF, 16'hBEEF, PROG_CYCLES, 0, 0, "R3 boot top program");
        boot_lock = 1'b1;
        run_op(2'b01, 16'h0100, 16'h0000, PROG_CYCLES, 0, 0, "R9 locked program busy length");
        do_read(16'h0100, "R9 locked boot word unchanged");
        run_op(2'b01, 16'h4000, 16'h00FF, PROG_CYCLES, 0, 0, "R9 main program while locked");
        do_read(16'h4000, "R9 main word programmed while locked");

        // R8 chip erase with lock
        run_op(2'b10, 0, '0, (FULL_SIZE - BOOT_SIZE) + ERASE_CYCLES, 2, 0, "R8 locked chip erase length");
        do_read(16'h0100, "R8 boot word kept");
        do_read(16'h1FFF, "R8 boot top kept");
        do_read(16'h2000, "R8 main base erased");
        do_read(16'h4000, "R8 main word erased");
        do_read(16'h7FFF, "R8 top erased");

        // R6 main erase
        boot_lock = 1'b0;
        run_op(2'b01, 16'h2000, 16'h0000, PROG_CYCLES, 0, 0, "R3 program main base");
        run_op(2'b11, 0, '0, (FULL_SIZE - BOOT_SIZE) + ERASE_CYCLES, 1, 0, "R6 main erase length");
        do_read(16'h2000, "R6 main base erased");
        do_read(16'h1FFF, "R6 boot top kept");
        do_read(16'h0100, "R6 boot word kept");

        // R7 chip erase unlocked
        run_op(2'b10, 0, '0, FULL_SIZE + ERASE_CYCLES, 1, 0, "R7 chip erase length");
        do_read(16'h0100, "R7 boot word erased");
        do_read(16'h1FFF, "R7 boot top erased");
        do_read(16'h0000, "R7 bottom erased");

        repeat (4) @(negedge clk);
        chk("R2 all reads answered", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule